// File: doc/BRIEF.md
# Stacked flash chip-select router

This block sits between a serial flash command engine and a row of serial flash devices. The devices are mapped one after another into a single linear address space. Each host request gives an opcode, a start address, a dummy cycle count and a byte length. From the start address and the length, the router picks the device to select and works out the address inside that device. It then hands one sub-transaction at a time to the serial engine.

When a request runs past the end of one device, the router splits it. The first piece covers the data up to the end of the starting device. Each following piece goes to the next device and starts at its local address zero. Every piece carries the full command again: opcode, address, dummy count and its share of the data. Only one chip select is ever active. Chip select is dropped between pieces, and the next piece is offered only after the engine reports the previous one complete.

The host uses a request/accept handshake. The router replies with a single-cycle response pulse that carries an error flag. A request that does not fit inside the total capacity is refused with the error flag set and selects no device.

Top module: `sfcs_router`

## Requirements
- R1: At most one bit of `sub_cs` is high in any cycle; bit i selects device i, and the first device selected for a request is start address divided by the per-device capacity.
- R2: The first sub-transaction of a request carries local address equal to the start address modulo the per-device capacity.
- R3: The first sub-transaction carries min(length, capacity − local address) bytes.
- R4: Each later sub-transaction targets the next higher device, carries local address 0 and min(remaining bytes, capacity) bytes, until the full length is covered.
- R5: Every sub-transaction repeats the request's opcode and dummy count.
- R6: After `sub_done`, chip select is low for at least one cycle before the next sub-transaction, and no new sub-transaction is offered while one is in flight.
- R7: A zero-length request yields exactly one sub-transaction with length 0, sent to the device decoded from the start address.
- R8: A request whose start address is at or beyond the total capacity, or whose start plus length exceeds it, gets `rsp_valid` with `rsp_err`=1 in the cycle after acceptance, and no chip select is asserted.
- R9: One cycle after the last `sub_done`, `rsp_valid` pulses for one cycle with `rsp_err`=0; `req_ready` is high only when no request is in progress.
- R10: After reset, `req_ready` is 1 and `sub_valid`, `sub_cs` and `rsp_valid` are 0.
- R11: While `sub_valid` is high and `sub_ready` is low, `sub_valid`, `sub_cs`, `sub_addr` and `sub_len` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Router idle and accepting a request |
| req_op | input | OP_W | Command opcode |
| req_addr | input | ADDR_W | Linear start address |
| req_dummy | input | DUM_W | Dummy cycle count |
| req_len | input | LEN_W | Byte length (0 = command only) |
| rsp_valid | output | 1 | Single-cycle completion pulse |
| rsp_err | output | 1 | Request refused (valid with rsp_valid) |
| sub_valid | output | 1 | Sub-transaction offered to the engine |
| sub_ready | input | 1 | Engine takes the offered sub-transaction |
| sub_done | input | 1 | Engine finished the taken sub-transaction |
| sub_cs | output | NUM_DEV | One-hot device chip select, active high |
| sub_op | output | OP_W | Opcode of the sub-transaction |
| sub_addr | output | DEV_AW | Device-local start address |
| sub_dummy | output | DUM_W | Dummy cycle count of the sub-transaction |
| sub_len | output | LEN_W | Byte count of the sub-transaction |

## Verification
The bench builds the router with three devices of 64 bytes each, 9-bit addresses and 9-bit lengths. Three devices is not a power of two, so the range check cannot rely on dropped high address bits, and addresses from 192 up to 511 exercise refusal. The small capacity lets lengths up to 192 cross one or two device boundaries and lets the bench hit the exact last byte of each device. Random engine delays on accept and completion stretch both the hold and gap behaviour.

// File: rtl/sfcs_pkg.sv
package sfcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_BUSY  = 3'd2,
        ST_GAP   = 3'd3,
        ST_RESP  = 3'd4
    } rt_state_e;

endpackage

// File: rtl/sfcs_addr_decode.sv
module sfcs_addr_decode #(
    parameter int NUM_DEV = 4,
    parameter int DEV_AW  = 16,
    parameter int ADDR_W  = 20,
    parameter int LEN_W   = 16,
    parameter int DEV_W   = 2,
    parameter int SUM_W   = 21
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [DEV_W-1:0]  dev_o,
    output logic [DEV_AW-1:0] la_o,
    output logic              bad_o
);
    localparam logic [SUM_W-1:0] TOTAL = SUM_W'(NUM_DEV) << DEV_AW;

    logic [SUM_W-1:0] start_x;
    logic [SUM_W-1:0] end_x;

    assign start_x = SUM_W'(addr_i);
    assign end_x   = start_x + SUM_W'(len_i);

    // the whole span must lie inside the stacked space
    assign bad_o = (start_x >= TOTAL) || (end_x > TOTAL);
    assign dev_o = DEV_W'(addr_i >> DEV_AW);
    assign la_o  = addr_i[DEV_AW-1:0];

endmodule

// File: rtl/sfcs_chunk.sv
module sfcs_chunk #(
    parameter int DEV_AW = 16,
    parameter int LEN_W  = 16
) (
    input  logic [DEV_AW-1:0] la_i,
    input  logic [LEN_W-1:0]  rem_i,
    output logic [LEN_W-1:0]  chunk_o
);
    localparam int CW = (LEN_W > DEV_AW + 1) ? LEN_W : DEV_AW + 1;
    localparam logic [CW-1:0] CAP_X = CW'(1) << DEV_AW;

    logic [CW-1:0] room;
    logic [CW-1:0] rem_x;

    // bytes left before the current device ends
    assign room    = CAP_X - CW'(la_i);
    assign rem_x   = CW'(rem_i);
    assign chunk_o = (rem_x < room) ? rem_i : LEN_W'(room);

endmodule

// File: rtl/sfcs_cs_drive.sv
module sfcs_cs_drive #(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 2
) (
    input  logic               en_i,
    input  logic [DEV_W-1:0]   dev_i,
    output logic [NUM_DEV-1:0] cs_o
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_cs
        assign cs_o[i] = en_i && (dev_i == DEV_W'(i));
    end

endmodule

// File: rtl/sfcs_router.sv
module sfcs_router
    import sfcs_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int DEV_AW  = 16,
    parameter int ADDR_W  = 20,
    parameter int LEN_W   = 16,
    parameter int OP_W    = 8,
    parameter int DUM_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [OP_W-1:0]    req_op,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DUM_W-1:0]   req_dummy,
    input  logic [LEN_W-1:0]   req_len,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic               sub_valid,
    input  logic               sub_ready,
    input  logic               sub_done,
    output logic [NUM_DEV-1:0] sub_cs,
    output logic [OP_W-1:0]    sub_op,
    output logic [DEV_AW-1:0]  sub_addr,
    output logic [DUM_W-1:0]   sub_dummy,
    output logic [LEN_W-1:0]   sub_len
);
    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int MAX_W = (ADDR_W > LEN_W) ? ADDR_W : LEN_W;
    localparam int SUM_W = ((MAX_W > DEV_AW + DEV_W) ? MAX_W : DEV_AW + DEV_W) + 1;
    localparam int CAP   = 1 << DEV_AW;

    typedef struct packed {
        rt_state_e         st;
        logic [DEV_W-1:0]  dev;
        logic [DEV_AW-1:0] la;
        logic [LEN_W-1:0]  rem;
        logic [OP_W-1:0]   op;
        logic [DUM_W-1:0]  dum;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic [DEV_W-1:0]  dec_dev;
    logic [DEV_AW-1:0] dec_la;
    logic              dec_bad;
    logic [LEN_W-1:0]  chunk;
    logic              cs_en;

    sfcs_addr_decode #(
        .NUM_DEV(NUM_DEV), .DEV_AW(DEV_AW), .ADDR_W(ADDR_W),
        .LEN_W(LEN_W), .DEV_W(DEV_W), .SUM_W(SUM_W)
    ) i_decode (
        .addr_i(req_addr), .len_i(req_len),
        .dev_o(dec_dev), .la_o(dec_la), .bad_o(dec_bad)
    );

    sfcs_chunk #(.DEV_AW(DEV_AW), .LEN_W(LEN_W)) i_chunk (
        .la_i(r_q.la), .rem_i(r_q.rem), .chunk_o(chunk)
    );

    assign cs_en = (r_q.st == ST_ISSUE) || (r_q.st == ST_BUSY);

    sfcs_cs_drive #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) i_cs (
        .en_i(cs_en), .dev_i(r_q.dev), .cs_o(sub_cs)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.op  = req_op;
                    r_d.dum = req_dummy;
                    r_d.dev = dec_dev;
                    r_d.la  = dec_la;
                    r_d.rem = req_len;
                    r_d.err = dec_bad;
                    r_d.st  = dec_bad ? ST_RESP : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (sub_ready) r_d.st = ST_BUSY;
            end
            ST_BUSY: begin
                if (sub_done) begin
                    if (r_q.rem == chunk) begin
                        r_d.st = ST_RESP;
                    end else begin
                        r_d.st  = ST_GAP;
                        r_d.rem = r_q.rem - chunk;
                        r_d.dev = r_q.dev + DEV_W'(1);
                        r_d.la  = '0;
                    end
                end
            end
            ST_GAP:  r_d.st = ST_ISSUE;
            ST_RESP: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign rsp_valid = (r_q.st == ST_RESP);
    assign rsp_err   = (r_q.st == ST_RESP) && r_q.err;
    assign sub_valid = (r_q.st == ST_ISSUE);
    assign sub_op    = r_q.op;
    assign sub_dummy = r_q.dum;
    assign sub_addr  = r_q.la;
    assign sub_len   = chunk;

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sub_cs));

    // R3
    chunk_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> (32'(sub_addr) + 32'(sub_len) <= 32'(CAP)));

    // R4
    next_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_GAP) |=> (sub_valid && sub_addr == '0));

    // R6
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_done && r_q.st == ST_BUSY) |=> (sub_cs == '0 && !sub_valid));

    // R8
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && dec_bad) |=> (rsp_valid && rsp_err && sub_cs == '0));

    // R11
    sub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !sub_ready) |=>
        (sub_valid && $stable(sub_cs) && $stable(sub_addr) && $stable(sub_len)));

endmodule

// File: tb/test_sfcs_router.sv
module test_sfcs_router;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_DEV = 3;
    localparam int DEV_AW  = 6;
    localparam int ADDR_W  = 9;
    localparam int LEN_W   = 9;
    localparam int OP_W    = 8;
    localparam int DUM_W   = 5;
    localparam int CAP     = 1 << DEV_AW;
    localparam int TOTAL   = NUM_DEV * CAP;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [OP_W-1:0]    req_op = '0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [DUM_W-1:0]   req_dummy = '0;
    logic [LEN_W-1:0]   req_len = '0;
    logic               rsp_valid;
    logic               rsp_err;
    logic               sub_valid;
    logic               sub_ready = 1'b0;
    logic               sub_done = 1'b0;
    logic [NUM_DEV-1:0] sub_cs;
    logic [OP_W-1:0]    sub_op;
    logic [DEV_AW-1:0]  sub_addr;
    logic [DUM_W-1:0]   sub_dummy;
    logic [LEN_W-1:0]   sub_len;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfcs_router #(
        .NUM_DEV(NUM_DEV), .DEV_AW(DEV_AW), .ADDR_W(ADDR_W),
        .LEN_W(LEN_W), .OP_W(OP_W), .DUM_W(DUM_W)
    ) i_sfcs_router (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_dummy(req_dummy), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_done(sub_done),
        .sub_cs(sub_cs), .sub_op(sub_op), .sub_addr(sub_addr),
        .sub_dummy(sub_dummy), .sub_len(sub_len)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_bad(input int addr, input int len);
        return (addr >= TOTAL) || (addr + len > TOTAL);
    endfunction

    function automatic int exp_chunk(input int la, input int rem);
        return (rem < CAP - la) ? rem : CAP - la;
    endfunction

    // one sub-transaction, entered at the negedge where it is offered
    task automatic do_sub(input int dev, input int la, input int len,
                          input int op, input int dum, input bit first);
        logic [NUM_DEV-1:0] ecs;
        ecs = NUM_DEV'(1 << dev);
        chk(sub_valid == 1'b1, "R6 sub offered", int'(sub_valid), 1);
        chk(sub_cs == ecs, "R1 chip select", int'(sub_cs), int'(ecs));
        chk(int'(sub_addr) == la, first ? "R2 local address" : "R4 local address",
            int'(sub_addr), la);
        chk(int'(sub_len) == len, first ? "R3 first length" : "R4 later length",
            int'(sub_len), len);
        chk(int'(sub_op) == op && int'(sub_dummy) == dum, "R5 opcode/dummy",
            int'(sub_op), op);
        for (int w = $urandom % 3; w > 0; w--) begin
            @(negedge clk);
            chk(sub_valid && sub_cs == ecs && int'(sub_addr) == la && int'(sub_len) == len,
                "R11 hold", int'(sub_len), len);
        end
        sub_ready = 1'b1;
        @(negedge clk);
        sub_ready = 1'b0;
        for (int w = $urandom % 4; w >= 0; w--) begin
            chk(!sub_valid && sub_cs == ecs, "R6 in flight", int'(sub_cs), int'(ecs));
            if (w > 0) @(negedge clk);
        end
        sub_done = 1'b1;
        @(negedge clk);
        sub_done = 1'b0;
        chk(sub_cs == '0, "R6 cs released", int'(sub_cs), 0);
    endtask

    task automatic run(input int op, input int addr, input int dum, input int len);
        int dev, la, rem, c;
        bit first;
        @(negedge clk);
        req_op = OP_W'(op);
        req_addr = ADDR_W'(addr);
        req_dummy = DUM_W'(dum);
        req_len = LEN_W'(len);
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R9 ready idle", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_bad(addr, len)) begin
            chk(rsp_valid && rsp_err, "R8 reject", int'({rsp_valid, rsp_err}), 3);
            chk(sub_cs == '0 && !sub_valid, "R8 no cs", int'(sub_cs), 0);
            return;
        end
        dev = addr / CAP;
        la = addr % CAP;
        rem = len;
        first = 1;
        do begin
            c = exp_chunk(la, rem);
            if (len == 0) chk(c == 0, "R7 zero length", int'(sub_len), 0);
            do_sub(dev, la, c, op, dum, first);
            rem -= c;
            dev++;
            la = 0;
            first = 0;
            if (rem > 0) begin
                chk(!sub_valid, "R6 gap", int'(sub_valid), 0);
                @(negedge clk);
            end
        end while (rem > 0);
        chk(rsp_valid && !rsp_err, "R9 done pulse", int'({rsp_valid, rsp_err}), 2);
        chk(!req_ready, "R9 busy not ready", int'(req_ready), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        chk(req_ready && !sub_valid && sub_cs == '0 && !rsp_valid, "R10 reset state",
            int'(sub_cs), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !sub_valid && sub_cs == '0 && !rsp_valid, "R10 after reset",
            int'(sub_cs), 0);
        // directed corner cases
        run(8'h03, 70, 0, 0);     // R7 zero length in device 1
        run(8'h0b, 0, 8, 0);      // R7 zero length at address 0
        run(8'h03, 63, 0, 1);     // last byte of device 0
        run(8'h6b, 63, 4, 2);     // R4 one byte on each side of a boundary
        run(8'h02, 0, 0, 192);    // spans all three devices
        run(8'h03, 191, 2, 1);    // last byte of the space
        run(8'h03, 128, 0, 64);   // exactly fills the last device
        run(8'h03, 192, 0, 0);    // R8 start at total capacity
        run(8'h03, 100, 0, 93);   // R8 end one past capacity
        run(8'h03, 511, 1, 5);    // R8 far beyond
        // random mix
        for (int k = 0; k < 60; k++) begin
            int a, l;
            a = ($urandom % 5 == 0) ? int'($urandom % 512) : int'($urandom % TOTAL);
            l = ($urandom % 6 == 0) ? 0 : int'($urandom % 150);
            run(int'($urandom % 256), a, int'($urandom % 32), l);
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 idle at end", int'(req_ready), 1);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule